// File: doc/BRIEF.md
# Element Zero-Count and Population-Count Unit

This block counts bits inside one vector element per transfer. A 64-bit operand arrives with a run-time element-width select and an operation select. The unit returns the number of leading zeros, the number of trailing zeros, or the number of set bits of that element. The element is read as an unsigned value made of the low SEW bits of the operand. The 7-bit count is zero-extended onto a 64-bit result bus one registered cycle after the operand is accepted.

Both sides are valid/ready streams. An operand transfers on a rising edge where `in_valid` and `in_ready` are both high. A result transfers on a rising edge where `out_valid` and `out_ready` are both high. The unit holds one result register. `in_ready` is high while that register is empty or is being drained in the same cycle, so with `out_ready` held high the unit takes one operand per cycle. While the consumer holds `out_ready` low, the pending result stays frozen and no new operand is taken.

Top module: `elem_bitcount`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first accepted operand, `out_valid` is low.
- R2: An operand accepted on edge N (`in_valid` and `in_ready` both high) gives `out_valid` high with its result after edge N+1's predecessor, that is, visible from edge N onward. `in_ready` equals `!out_valid || out_ready`.
- R3: While `out_valid` is high and `out_ready` is low, `out_result` and `out_valid` hold their values, and no operand is accepted.
- R4: `in_width` selects SEW as follows: 2'b00 = 8, 2'b01 = 16, 2'b10 = 32, 2'b11 = 64. Operand bits at SEW and above have no effect on any operation.
- R5: With `in_op` = 2'b00 the result is the number of zero bits scanned from bit SEW-1 downward before the first set bit.
- R6: With `in_op` = 2'b01 the result is the number of zero bits scanned from bit 0 upward before the first set bit.
- R7: For an element whose low SEW bits are all zero, both zero-count operations return SEW.
- R8: With `in_op` = 2'b10 the result is the number of set bits among the low SEW bits.
- R9: With `in_op` = 2'b11 the result is zero.
- R10: `out_result[63:7]` is always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Unit can take an operand this cycle |
| in_operand | input | 64 | Operand, element in the low SEW bits |
| in_width | input | 2 | Element width code (8/16/32/64) |
| in_op | input | 2 | Operation: 00 leading zeros, 01 trailing zeros, 10 set bits, 11 zero |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 64 | Zero-extended count |

## Verification
Draining a result and accepting the next operand can fall on the same edge. The bench provokes this by streaming operands back to back with `out_ready` high. Each result must then match its own operand and not its neighbour, and `in_ready` must never drop. A stall phase pins `out_ready` low while a new operand is offered. It then checks that the held result is unchanged and that the offered operand surfaces only after the stall lifts. Leading-zero and trailing-zero scans are swept with every single-bit operand at every width, including set bits above SEW, and compared against loop models.

// File: rtl/bitcount_pkg.sv
package bitcount_pkg;
  localparam int unsigned DATA_W = 64;
  localparam int unsigned CNT_W  = $clog2(DATA_W) + 1;
  localparam int unsigned N_SEW  = 4;

  typedef enum logic [1:0] {
    OP_LEAD  = 2'b00,
    OP_TRAIL = 2'b01,
    OP_ONES  = 2'b10,
    OP_NONE  = 2'b11
  } count_op_e;

  function automatic logic [CNT_W-1:0] sew_of(input logic [1:0] code);
    return CNT_W'(8) << code;
  endfunction
endpackage

// File: rtl/bc_elem_prep.sv
module bc_elem_prep
  import bitcount_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic [W-1:0] operand,
  input  logic [1:0]   width,
  output logic [W-1:0] low_elem,
  output logic [W-1:0] top_elem
);
  logic [W-1:0] low_c [N_SEW];
  logic [W-1:0] top_c [N_SEW];

  for (genvar g = 0; g < int'(N_SEW); g++) begin : g_sew
    localparam int unsigned EW = 8 << g;
    if (EW == W) begin : g_full
      assign low_c[g] = operand;
      assign top_c[g] = operand;
    end else begin : g_part
      assign low_c[g] = {{(W-EW){1'b0}}, operand[EW-1:0]};
      assign top_c[g] = {operand[EW-1:0], {(W-EW){1'b0}}};
    end
  end

  assign low_elem = low_c[width];
  assign top_elem = top_c[width];
endmodule

// File: rtl/bc_trail_count.sv
module bc_trail_count #(
  parameter int unsigned W = 64,
  localparam int unsigned CW = $clog2(W) + 1
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt
);
  always_comb begin
    cnt = CW'(W);
    for (int i = int'(W) - 1; i >= 0; i--) begin
      if (vec[i]) cnt = CW'(i);
    end
  end

  always_comb begin
    p_trail_bound_r6: assert (cnt <= CW'(W));
  end
endmodule

// File: rtl/bc_pop_count.sv
module bc_pop_count #(
  parameter int unsigned W = 64,
  localparam int unsigned CW = $clog2(W) + 1
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt
);
  always_comb begin
    cnt = '0;
    for (int i = 0; i < int'(W); i++) cnt = cnt + CW'(vec[i]);
  end

  always_comb begin
    p_pop_empty_r8: assert ((vec != '0) || (cnt == '0));
  end
endmodule

// File: rtl/elem_bitcount.sv
module elem_bitcount
  import bitcount_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [63:0] in_operand,
  input  logic [1:0]  in_width,
  input  logic [1:0]  in_op,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [63:0] out_result
);
  logic [DATA_W-1:0] low_elem, top_elem, top_rev;
  logic [CNT_W-1:0]  trail_cnt, lead_raw, ones_cnt, sew, lead_cnt, trail_clip, res_d;
  logic [CNT_W-1:0]  res_q;
  logic [1:0]        width_q;
  logic              valid_q;

  bc_elem_prep #(.W(DATA_W)) u_prep (
    .operand(in_operand), .width(in_width),
    .low_elem(low_elem), .top_elem(top_elem)
  );

  for (genvar b = 0; b < int'(DATA_W); b++) begin : g_rev
    assign top_rev[b] = top_elem[DATA_W-1-b];
  end

  bc_trail_count #(.W(DATA_W)) u_trail (.vec(low_elem), .cnt(trail_cnt));
  bc_trail_count #(.W(DATA_W)) u_lead  (.vec(top_rev),  .cnt(lead_raw));
  bc_pop_count   #(.W(DATA_W)) u_ones  (.vec(low_elem), .cnt(ones_cnt));

  assign sew        = sew_of(in_width);
  assign lead_cnt   = (lead_raw  > sew) ? sew : lead_raw;
  assign trail_clip = (trail_cnt > sew) ? sew : trail_cnt;

  always_comb begin
    unique case (count_op_e'(in_op))
      OP_LEAD:  res_d = lead_cnt;
      OP_TRAIL: res_d = trail_clip;
      OP_ONES:  res_d = ones_cnt;
      default:  res_d = '0;
    endcase
  end

  assign in_ready = !valid_q || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      res_q   <= '0;
      width_q <= '0;
    end else if (in_ready) begin
      valid_q <= in_valid;
      if (in_valid) begin
        res_q   <= res_d;
        width_q <= in_width;
      end
    end
  end

  assign out_valid  = valid_q;
  assign out_result = {{(64-CNT_W){1'b0}}, res_q};

  p_stall_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result)));
  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
  p_count_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_result <= 64'(sew_of(width_q))));
  p_upper_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_result[63:7] == '0));
endmodule

// File: tb/elem_bitcount_bench.sv
module elem_bitcount_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_operand = '0;
  logic [1:0]  in_width = '0;
  logic [1:0]  in_op = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_result;

  int n_vec = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  elem_bitcount u_elem_bitcount (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_operand(in_operand), .in_width(in_width), .in_op(in_op),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result)
  );

  function automatic int model(input logic [63:0] x, input logic [1:0] w, input logic [1:0] op);
    int sew;
    int n;
    sew = 8 << w;
    n = 0;
    if (op == 2'b00) begin
      n = sew;
      for (int i = 0; i < sew; i++) if (x[sew-1-i]) begin n = i; break; end
    end else if (op == 2'b01) begin
      n = sew;
      for (int i = 0; i < sew; i++) if (x[i]) begin n = i; break; end
    end else if (op == 2'b10) begin
      for (int i = 0; i < sew; i++) n += int'(x[i]);
    end
    return n;
  endfunction

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic string tag_of(input logic [1:0] op);
    case (op)
      2'b00:   return "R5";
      2'b01:   return "R6";
      2'b10:   return "R8";
      default: return "R9";
    endcase
  endfunction

  // drive at negedge, result visible at following negedge (R2)
  task automatic apply(input logic [63:0] x, input logic [1:0] w, input logic [1:0] op);
    in_operand = x; in_width = w; in_op = op; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R2", {63'b0, out_valid}, 64'd1);
    check(tag_of(op), out_result, 64'(model(x, w, op)));
    check("R10", {7'b0, out_result[63:7]}, 64'd0);
    check("R2", {63'b0, in_ready}, 64'd1);
  endtask

  initial begin
    @(negedge clk);
    check("R1", {63'b0, out_valid}, 64'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {63'b0, out_valid}, 64'd0);

    // single-bit sweep, bits above SEW included (R4)
    for (int w = 0; w < 4; w++)
      for (int b = 0; b < 64; b++)
        for (int op = 0; op < 4; op++)
          apply(64'd1 << b, 2'(w), 2'(op));

    // all-zero element with garbage above SEW (R7, R4)
    for (int w = 0; w < 3; w++) begin
      logic [63:0] x;
      x = ~((64'd1 << (8 << w)) - 64'd1);
      apply(x, 2'(w), 2'b00);
      check("R7", out_result, 64'(8 << w));
      apply(x, 2'(w), 2'b01);
      check("R7", out_result, 64'(8 << w));
      apply(x, 2'(w), 2'b10);
      check("R4", out_result, 64'd0);
    end
    apply(64'd0, 2'b11, 2'b00);
    check("R7", out_result, 64'd64);
    apply(64'd0, 2'b11, 2'b01);
    check("R7", out_result, 64'd64);
    apply('1, 2'b11, 2'b10);
    check("R8", out_result, 64'd64);

    // pseudo-random operands
    for (int k = 0; k < 600; k++) begin
      logic [63:0] x;
      x = {$urandom, $urandom};
      if (k % 3 == 1) x = x & {$urandom, $urandom};
      if (k % 3 == 2) x = x & {$urandom, $urandom} & {$urandom, $urandom};
      apply(x, 2'(k % 4), 2'((k / 4) % 4));
    end
    in_valid = 1'b0;
    @(negedge clk);

    // stall: hold result, refuse new operand (R3)
    apply(64'h0000_0000_0000_00F0, 2'b00, 2'b01);
    out_ready = 1'b0;
    in_operand = 64'h8000_0000_0000_0000; in_width = 2'b11; in_op = 2'b00;
    for (int s = 0; s < 4; s++) begin
      @(posedge clk);
      @(negedge clk);
      check("R3", out_result, 64'd4);
      check("R3", {63'b0, out_valid}, 64'd1);
      check("R3", {63'b0, in_ready}, 64'd0);
    end
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R3", out_result, 64'd0);
    check("R3", {63'b0, out_valid}, 64'd1);
    in_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R2", {63'b0, out_valid}, 64'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule